// File: doc/BRIEF.md
# Multi-drop 9-bit UART framing

This block carries the serial framing of a UART used on a shared multi-drop line. The transmitter sends a start bit, eight data bits least significant first, an optional ninth bit and one stop bit. In network mode the ninth bit tells address frames apart from data frames. The receiver captures the same frames and compares every address frame against a programmed 8-bit station address. It passes on only the traffic meant for this station. Without network mode, the ninth bit can carry plain 9-bit data words.

An 8-bit control word selects the modes and the serial output enable. The output enable can be released so that several stations share one line. A one-cycle oversampling enable paces both directions. Each bit lasts `OVS` enables, and the receiver samples in the middle of each bit.

Top module: `mdrop_uart9`

## Requirements
- R1: After reset, tx_out is 1, tx_busy is 0, and rx_valid, rx_err, addr_match, irq and tx_addr_sent are 0.
- R2: A transmit request (tx_start while tx_busy is 0) sends a frame in which each bit lasts OVS ticks: a 0 start bit, then tx_data[7:0] least significant bit first, then the ninth bit if enabled, then a 1 stop bit. tx_out is 1 while idle, and a request made while busy is ignored.
- R3: When ctrl[7] (network mode) and ctrl[6] (9-bit transmit) are both 1, the ninth bit sent equals ctrl[0]: 1 marks an address frame and 0 marks a data frame. With ctrl[7] at 0, ctrl[6] has no effect and the frame has 8 data bits, so tx_busy falls 10 bit times after the request.
- R4: With ctrl[3] at 1 and 9-bit transmit not in force, the ninth bit sent is tx_data[8]. The receiver then takes 9 bits and presents the ninth as rx_data[8]. In 8-bit framing, rx_data[8] is 0.
- R5: tx_oe equals ctrl[2] (1 drives the line, 0 releases it).
- R6: When ctrl[7] and ctrl[5] are both 1, a received frame is an address frame when its ninth bit XOR ctrl[1] is 1. An address frame whose low 8 bits equal station_addr pulses addr_match and rx_valid together, with rx_data = {ninth bit, address}. A non-matching address frame produces no rx_valid.
- R7: In that mode, data frames produce rx_valid only after a matching address, and only until the next non-matching address.
- R8: irq pulses together with addr_match when ctrl[4] is 1, and stays 0 when ctrl[4] is 0.
- R9: With ctrl[1] at 1, a ninth bit of 0 marks an address and a ninth bit of 1 marks data.
- R10: A stop bit sampled as 0 still delivers the word, with rx_err at 1. A good stop bit delivers rx_err at 0.
- R11: tx_addr_sent pulses for one cycle when a frame sent with ctrl[7], ctrl[6] and ctrl[0] all at 1 completes, and stays 0 for data frames.
- R12: With ctrl[7] at 0, every received frame gives rx_valid, no address comparison is made, and ctrl[5] has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling enable, OVS per bit |
| ctrl | input | 8 | Mode control word |
| station_addr | input | 8 | This station's network address |
| tx_data | input | 9 | Word to send; bit 8 used in 9-bit data mode |
| tx_start | input | 1 | Transmit request |
| tx_busy | output | 1 | Frame in progress |
| tx_out | output | 1 | Serial output |
| tx_oe | output | 1 | Serial output driver enable |
| tx_addr_sent | output | 1 | Pulse at the end of an address frame |
| rx_in | input | 1 | Serial input |
| rx_data | output | 9 | Last delivered word |
| rx_valid | output | 1 | Pulse: rx_data updated |
| rx_err | output | 1 | Framing error of the last delivered word |
| addr_match | output | 1 | Pulse: own address received |
| irq | output | 1 | Pulse: enabled address-match interrupt |

## Verification
With tick held at 1, transmit bit k is centred 8 + 16k cycles after the edge that accepts the request. The bench samples tx_out on the falling clock edge at each of those points and checks tx_busy after the last bit. A received word reaches the ports two synchronizer cycles, half a bit and n + 1 bit times after the start edge, plus one filter register. The bench leaves 40 idle cycles after each stop bit before it reads the rx_data port and its edge counters of rx_valid, addr_match, irq and tx_addr_sent, so that every pulse of a frame is counted before the next frame begins.

// File: rtl/mdrop_uart9_pkg.sv
// Shared control-bit positions, receiver states and mode decode helpers.
package mdrop_uart9_pkg;
    localparam int CB_NET = 7;  // network mode
    localparam int CB_TX9 = 6;  // ninth bit as address marker on transmit
    localparam int CB_RX9 = 5;  // ninth bit as address marker on receive
    localparam int CB_IRQ = 4;  // interrupt on address match
    localparam int CB_W9  = 3;  // plain 9-bit data words
    localparam int CB_DRV = 2;  // drive serial output
    localparam int CB_POL = 1;  // address-marker polarity
    localparam int CB_ADR = 0;  // send address frame

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_WAIT_HI
    } rx_state_t;

    // 9-bit data words count only while the address marker is not transmitted
    function automatic logic w9_eff(input logic [7:0] c);
        return c[CB_W9] & ~(c[CB_NET] & c[CB_TX9]);
    endfunction

    function automatic logic tx_ninth(input logic [7:0] c);
        return (c[CB_NET] & c[CB_TX9]) | w9_eff(c);
    endfunction

    function automatic logic rx_ninth(input logic [7:0] c);
        return (c[CB_NET] & c[CB_RX9]) | w9_eff(c);
    endfunction
endpackage

// File: rtl/mdrop_tx.sv
// Serial transmitter: start bit, DW data bits LSB first, an optional ninth
// bit and a stop bit, OVS ticks per bit. Assumes OVS is a power of two.
module mdrop_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          ninth_en,
    input  logic          ninth_val,
    input  logic          addr_frame,
    output logic          tx_out,
    output logic          busy,
    output logic          addr_sent
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(FW + 1);

    logic [FW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic          was_addr;

    // Load a frame on request, then shift one bit out every OVS ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            idx       <= '0;
            last_idx  <= '0;
            was_addr  <= 1'b0;
            busy      <= 1'b0;
            tx_out    <= 1'b1;
            addr_sent <= 1'b0;
        end else begin
            addr_sent <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    shreg    <= {1'b1, (ninth_en ? ninth_val : 1'b1), data, 1'b0};
                    tx_out   <= 1'b0;
                    cnt      <= '0;
                    idx      <= '0;
                    last_idx <= ninth_en ? IW'(FW - 1) : IW'(FW - 2);
                    was_addr <= addr_frame;
                end
            end else if (tick) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt <= '0;
                    if (idx == last_idx) begin
                        busy      <= 1'b0;
                        tx_out    <= 1'b1;
                        addr_sent <= was_addr;
                    end else begin
                        idx    <= idx + 1'b1;
                        shreg  <= shreg >> 1;
                        tx_out <= shreg[1];
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: an accepted request drives the start bit on the next cycle
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!tx_out && busy));
    // R2: the line rests high whenever no frame is in progress
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);
    // R11: the address-sent event appears only once the frame is over
    a_r11_sent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sent |-> !busy);
endmodule

// File: rtl/mdrop_rx.sv
// Serial receiver: synchronizes the line, qualifies the start bit at
// mid-bit and samples DW or DW+1 bits and the stop bit. It reports the raw
// word and a framing error. Assumes OVS is a power of two and at least 4.
module mdrop_rx #(
    parameter int DW    = 8,
    parameter int OVS   = 16,
    parameter int SYNCN = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        rx_in,
    input  logic        ninth_en,
    output logic        frm_valid,
    output logic [DW:0] frm_word,
    output logic        frm_err
);
    import mdrop_uart9_pkg::*;

    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW + 2);

    logic [SYNCN-1:0] sync;
    logic             line;
    rx_state_t        state;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [IW-1:0]    last_idx;
    logic [DW:0]      shreg;

    assign line = sync[SYNCN-1];

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[SYNCN-2:0], rx_in};
    end

    // Frame sequencer: start qualify, data bits, stop, wait for idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            last_idx  <= '0;
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm_word  <= '0;
            frm_err   <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            case (state)
                RX_IDLE: if (!line) begin
                    state    <= RX_START;
                    cnt      <= '0;
                    shreg    <= '0;
                    last_idx <= ninth_en ? IW'(DW) : IW'(DW - 1);
                end
                RX_START: if (tick) begin
                    if (cnt == CW'(OVS / 2 - 1)) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= line ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt        <= '0;
                        shreg[idx] <= line;
                        if (idx == last_idx) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt == CW'(OVS - 1)) begin
                        frm_valid <= 1'b1;
                        frm_word  <= shreg;
                        frm_err   <= !line;
                        state     <= line ? RX_IDLE : RX_WAIT_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAIT_HI: if (line) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R10: each frame yields a single-cycle word strobe
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);
endmodule

// File: rtl/mdrop_addr_filter.sv
// Station filter: classifies received words as address or data by the
// ninth bit and a polarity control, tracks whether this station is
// addressed, and gates delivery. Assumes one word strobe at a time.
module mdrop_addr_filter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ctrl,
    input  logic [DW-1:0] station_addr,
    input  logic          frm_valid,
    input  logic [DW:0]   frm_word,
    input  logic          frm_err,
    output logic          rx_valid,
    output logic [DW:0]   rx_data,
    output logic          rx_err,
    output logic          addr_match,
    output logic          irq
);
    import mdrop_uart9_pkg::*;

    logic net_rx;
    logic is_addr;
    logic hit;
    logic selected;
    logic deliver;

    assign net_rx  = ctrl[CB_NET] & ctrl[CB_RX9];
    assign is_addr = frm_word[DW] ^ ctrl[CB_POL];
    assign hit     = is_addr && (frm_word[DW-1:0] == station_addr);

    // Decide whether the current word is for this station
    always_comb begin
        if (!net_rx)      deliver = 1'b1;
        else if (is_addr) deliver = hit;
        else              deliver = selected;
    end

    // Register delivery, track selection and raise match events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selected   <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_err     <= 1'b0;
            addr_match <= 1'b0;
            irq        <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            addr_match <= 1'b0;
            irq        <= 1'b0;
            if (frm_valid) begin
                if (net_rx && is_addr) selected <= hit;
                if (deliver) begin
                    rx_valid <= 1'b1;
                    rx_data  <= frm_word;
                    rx_err   <= frm_err;
                end
                if (net_rx && hit) begin
                    addr_match <= 1'b1;
                    irq        <= ctrl[CB_IRQ];
                end
            end
        end
    end

    // R6: a match always comes with the delivered address word
    a_r6_match_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> rx_valid);
    // R8: the interrupt is only ever raised by an address match
    a_r8_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> addr_match);
endmodule

// File: rtl/mdrop_uart9.sv
// Top of the multi-drop 9-bit UART framing: decodes the control word and
// connects the transmitter, receiver and station filter. Assumes tick is a
// single-cycle enable, OVS per bit, shared by both directions.
module mdrop_uart9 #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [7:0]        ctrl,
    input  logic [DATA_W-1:0] station_addr,
    input  logic [DATA_W:0]   tx_data,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic              tx_out,
    output logic              tx_oe,
    output logic              tx_addr_sent,
    input  logic              rx_in,
    output logic [DATA_W:0]   rx_data,
    output logic              rx_valid,
    output logic              rx_err,
    output logic              addr_match,
    output logic              irq
);
    import mdrop_uart9_pkg::*;

    logic              net_tx;
    logic              ninth_val;
    logic              frm_valid;
    logic [DATA_W:0]   frm_word;
    logic              frm_err;

    assign net_tx    = ctrl[CB_NET] & ctrl[CB_TX9];
    assign ninth_val = net_tx ? ctrl[CB_ADR] : tx_data[DATA_W];
    assign tx_oe     = ctrl[CB_DRV];

    mdrop_tx #(.DW(DATA_W), .OVS(OVS)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (tx_start),
        .data      (tx_data[DATA_W-1:0]),
        .ninth_en  (tx_ninth(ctrl)),
        .ninth_val (ninth_val),
        .addr_frame(net_tx & ctrl[CB_ADR]),
        .tx_out    (tx_out),
        .busy      (tx_busy),
        .addr_sent (tx_addr_sent)
    );

    mdrop_rx #(.DW(DATA_W), .OVS(OVS), .SYNCN(2)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx_in    (rx_in),
        .ninth_en (rx_ninth(ctrl)),
        .frm_valid(frm_valid),
        .frm_word (frm_word),
        .frm_err  (frm_err)
    );

    mdrop_addr_filter #(.DW(DATA_W)) flt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .station_addr(station_addr),
        .frm_valid   (frm_valid),
        .frm_word    (frm_word),
        .frm_err     (frm_err),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_err      (rx_err),
        .addr_match  (addr_match),
        .irq         (irq)
    );
endmodule

// File: tb/mdrop_uart9_tb_top.sv
// Directed bench for the multi-drop 9-bit UART framing.
module mdrop_uart9_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic [7:0] station_addr = 8'h42;
    logic [8:0] tx_data = '0;
    logic       tx_start = 1'b0;
    logic       drv_rx = 1'b1;
    logic       loop_en = 1'b0;
    logic       rx_in;
    logic       tx_busy, tx_out, tx_oe, tx_addr_sent;
    logic [8:0] rx_data;
    logic       rx_valid, rx_err, addr_match, irq;

    int checks = 0;
    int fails = 0;
    int n_valid = 0, n_match = 0, n_irq = 0, n_sent = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign rx_in = loop_en ? tx_out : drv_rx;

    mdrop_uart9 #(.DATA_W(8), .OVS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .ctrl(ctrl),
        .station_addr(station_addr), .tx_data(tx_data), .tx_start(tx_start),
        .tx_busy(tx_busy), .tx_out(tx_out), .tx_oe(tx_oe),
        .tx_addr_sent(tx_addr_sent), .rx_in(rx_in), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_err(rx_err), .addr_match(addr_match), .irq(irq)
    );

    // Count output pulses and watch for a hung run
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rx_valid)     n_valid <= n_valid + 1;
        if (addr_match)   n_match <= n_match + 1;
        if (irq)          n_irq   <= n_irq + 1;
        if (tx_addr_sent) n_sent  <= n_sent + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Send one frame on the receive line
    task automatic send_rx(input logic [7:0] b, input bit has9, input bit n9, input bit stopv);
        @(negedge clk) drv_rx = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rx = b[i];
            repeat (16) @(negedge clk);
        end
        if (has9) begin
            drv_rx = n9;
            repeat (16) @(negedge clk);
        end
        drv_rx = stopv;
        repeat (16) @(negedge clk);
        drv_rx = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    // Request a transmission and sample 11 mid-bit points; report busy after
    task automatic tx_capture(input logic [8:0] d, output logic [10:0] bits, output logic busy_late);
        @(negedge clk);
        tx_data = d;
        tx_start = 1'b1;
        @(posedge clk);
        @(negedge clk) tx_start = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk) bits[0] = tx_out;
        for (int k = 1; k < 11; k++) begin
            repeat (16) @(negedge clk);
            bits[k] = tx_out;
        end
        busy_late = tx_busy;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_out == 1'b1, "R1 tx_out idle", tx_out, 1);
        chk(tx_busy == 1'b0, "R1 tx_busy", tx_busy, 0);
        chk({rx_valid, rx_err, addr_match, irq, tx_addr_sent} == 5'b0, "R1 outputs low",
            {rx_valid, rx_err, addr_match, irq, tx_addr_sent}, 0);
    endtask

    task automatic t_tx_plain();
        logic [10:0] b;
        logic bl;
        ctrl = 8'h04;
        tx_capture(9'h0A5, b, bl);
        chk(b == {2'b11, 8'hA5, 1'b0}, "R2 8-bit frame", b, {2'b11, 8'hA5, 1'b0});
        chk(bl == 1'b0, "R2 busy ends after 10 bits", bl, 0);
        chk(tx_oe == 1'b1, "R5 drive on", tx_oe, 1);
        ctrl = 8'h00;
        #1 chk(tx_oe == 1'b0, "R5 drive off", tx_oe, 0);
    endtask

    task automatic t_tx_busy_ignore();
        logic [10:0] b;
        logic bl;
        ctrl = 8'h04;
        // a second request in the middle of the frame must not disturb it
        fork
            tx_capture(9'h03C, b, bl);
            begin
                repeat (40) @(negedge clk);
                tx_data = 9'h0FF;
                tx_start = 1'b1;
                @(negedge clk) tx_start = 1'b0;
            end
        join
        chk(b == {2'b11, 8'h3C, 1'b0}, "R2 request while busy ignored", b, {2'b11, 8'h3C, 1'b0});
    endtask

    task automatic t_tx_net();
        logic [10:0] b;
        logic bl;
        int s0;
        ctrl = 8'hC5;
        s0 = n_sent;
        tx_capture(9'h03C, b, bl);
        chk(b == {2'b11, 8'h3C, 1'b0}, "R3 address marker 1", b, {2'b11, 8'h3C, 1'b0});
        chk(bl == 1'b1, "R3 11-bit frame busy", bl, 1);
        chk(n_sent == s0 + 1, "R11 address sent event", n_sent, s0 + 1);
        ctrl = 8'hCC;
        s0 = n_sent;
        tx_capture(9'h13C, b, bl);
        chk(b == {2'b10, 8'h3C, 1'b0}, "R3 data marker 0, 9-bit word ignored", b, {2'b10, 8'h3C, 1'b0});
        chk(n_sent == s0, "R11 no event for data", n_sent, s0);
        ctrl = 8'h44;
        tx_capture(9'h03C, b, bl);
        chk(bl == 1'b0, "R3 tx9 without network mode is 8-bit", bl, 0);
    endtask

    task automatic t_word9();
        logic [10:0] b;
        logic bl;
        ctrl = 8'h0C;
        tx_capture(9'h15A, b, bl);
        chk(b == {2'b11, 8'h5A, 1'b0}, "R4 ninth bit 1 from tx_data", b, {2'b11, 8'h5A, 1'b0});
        tx_capture(9'h05A, b, bl);
        chk(b == {2'b10, 8'h5A, 1'b0}, "R4 ninth bit 0 from tx_data", b, {2'b10, 8'h5A, 1'b0});
        send_rx(8'h77, 1'b1, 1'b1, 1'b1);
        chk(rx_data == 9'h177, "R4 9-bit receive", rx_data, 9'h177);
    endtask

    task automatic t_plain_rx();
        int v0;
        ctrl = 8'h20;
        v0 = n_valid;
        send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
        chk(n_valid == v0 + 1, "R12 plain frame delivered", n_valid, v0 + 1);
        chk(rx_data == 9'h0C3, "R12 plain data, bit 8 zero", rx_data, 9'h0C3);
        chk(rx_err == 1'b0, "R10 good stop", rx_err, 0);
    endtask

    task automatic t_filter();
        int v0, m0, i0;
        ctrl = 8'hA0;
        v0 = n_valid; m0 = n_match; i0 = n_irq;
        send_rx(8'h42, 1'b1, 1'b1, 1'b1);
        chk(n_match == m0 + 1, "R6 own address matched", n_match, m0 + 1);
        chk(rx_data == 9'h142 && n_valid == v0 + 1, "R6 address delivered", rx_data, 9'h142);
        chk(n_irq == i0, "R8 no irq when disabled", n_irq, i0);
        send_rx(8'h11, 1'b1, 1'b0, 1'b1);
        chk(rx_data == 9'h011 && n_valid == v0 + 2, "R7 data after match", rx_data, 9'h011);
        send_rx(8'h43, 1'b1, 1'b1, 1'b1);
        chk(n_valid == v0 + 2 && n_match == m0 + 1, "R6 foreign address dropped", n_valid, v0 + 2);
        send_rx(8'h22, 1'b1, 1'b0, 1'b1);
        chk(n_valid == v0 + 2 && rx_data == 9'h011, "R7 data after foreign address dropped", rx_data, 9'h011);
    endtask

    task automatic t_irq_pol();
        int i0, v0;
        ctrl = 8'hB0;
        i0 = n_irq;
        send_rx(8'h42, 1'b1, 1'b1, 1'b1);
        chk(n_irq == i0 + 1, "R8 irq on match", n_irq, i0 + 1);
        ctrl = 8'hA2;
        v0 = n_valid;
        send_rx(8'h42, 1'b1, 1'b0, 1'b1);
        chk(rx_data == 9'h042 && n_valid == v0 + 1, "R9 inverted address marker", rx_data, 9'h042);
        send_rx(8'h55, 1'b1, 1'b1, 1'b1);
        chk(rx_data == 9'h155 && n_valid == v0 + 2, "R9 inverted data marker", rx_data, 9'h155);
    endtask

    task automatic t_frame_err();
        int v0;
        ctrl = 8'h00;
        v0 = n_valid;
        send_rx(8'h5E, 1'b0, 1'b0, 1'b0);
        chk(n_valid == v0 + 1 && rx_data == 9'h05E, "R10 word kept on bad stop", rx_data, 9'h05E);
        chk(rx_err == 1'b1, "R10 framing error flagged", rx_err, 1);
        send_rx(8'h01, 1'b0, 1'b0, 1'b1);
        chk(rx_err == 1'b0, "R10 error clears on good frame", rx_err, 0);
    endtask

    task automatic t_loop();
        logic [10:0] b;
        logic bl;
        int m0;
        ctrl = 8'hE5;
        loop_en = 1'b1;
        m0 = n_match;
        tx_capture(9'h042, b, bl);
        repeat (20) @(negedge clk);
        chk(n_match == m0 + 1 && rx_data == 9'h142, "R6 loopback address match", rx_data, 9'h142);
        loop_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_tx_plain();
        t_tx_busy_ignore();
        t_tx_net();
        t_word9();
        t_plain_rx();
        t_filter();
        t_irq_pol();
        t_frame_err();
        t_loop();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule